// File: doc/BRIEF.md
# Drink Dispenser Event Controller

This block is a synchronous controller for a drink dispenser. It reacts to single-cycle input strobes. A coffee request and a tea request each carry the amount the customer paid, and the brewing unit sends a ready strobe. A request is accepted only when the paid amount is strictly above that drink's price. When a request is accepted, the controller sends a one-cycle make order to the brewing unit and remembers the amount. It then waits for ready. On ready it returns to idle, pulses the matching pour event, and presents the change: the amount paid minus the price.

Every reaction is atomic. In one clock edge the controller checks whether an event is present, reads the value that came with it, evaluates the price guard, updates its state and registers its output pulses. Both prices are parameters. Amounts and change are unsigned and `AMT_W` bits wide.

Top module: `vend_event_ctrl`

## Requirements
- R1: In idle, a coffee strobe whose amount is strictly greater than `COFFEE_PRICE` produces a one-cycle `make_coffee` pulse in the cycle after the strobe, and the controller enters the coffee-brewing state.
- R2: In idle, with no coffee strobe present, a tea strobe whose amount is strictly greater than `TEA_PRICE` produces a one-cycle `make_tea` pulse in the cycle after the strobe, and the controller enters the tea-brewing state.
- R3: A request whose amount is equal to or below its price is consumed with no output pulse, and the controller stays idle. A later ready strobe therefore produces no pour, and a later valid request is still accepted.
- R4: While brewing coffee, a ready strobe produces, in the next cycle and for one cycle, `pour_coffee` = 1, `change_vld` = 1 and `change_amt` = accepted amount − `COFFEE_PRICE`. The controller then returns to idle.
- R5: While brewing tea, a ready strobe produces, in the next cycle and for one cycle, `pour_tea` = 1, `change_vld` = 1 and `change_amt` = accepted amount − `TEA_PRICE`. The controller then returns to idle.
- R6: Requests that arrive while brewing are ignored. This includes a request in the same cycle as ready. Such a request gives no make pulse and leaves the held amount unchanged.
- R7: When coffee and tea strobes arrive in the same idle cycle, only the coffee request is evaluated and the tea strobe is dropped.
- R8: A ready strobe that arrives while idle has no effect.
- R9: All output events are one-cycle pulses, and at most one of `make_coffee`, `make_tea`, `pour_coffee` and `pour_tea` is high in any cycle. `change_amt` reads 0 whenever `change_vld` is low.
- R10: A synchronous active-high reset returns the controller to idle with every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coffee_req | input | 1 | Coffee request strobe |
| coffee_amt | input | AMT_W | Amount paid with the coffee request |
| tea_req | input | 1 | Tea request strobe |
| tea_amt | input | AMT_W | Amount paid with the tea request |
| brew_ready | input | 1 | Brewing unit finished strobe |
| make_coffee | output | 1 | Order to brew coffee |
| make_tea | output | 1 | Order to brew tea |
| pour_coffee | output | 1 | Coffee pour event |
| pour_tea | output | 1 | Tea pour event |
| change_vld | output | 1 | Change value is valid this cycle |
| change_amt | output | AMT_W | Change returned to the customer |

## Verification
The bench uses the default parameters: an 8-bit amount, a coffee price of 50 and a tea price of 30. These prices are low enough that one 8-bit bus covers the rejected values at and just below each price, the first accepted value (change of 1), and the full-scale amount 255 (change of 205 for coffee, 225 for tea). Because the two prices differ, a change value computed with the wrong drink's price shows up at the ports.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COFFEE = 2'd1,
    ST_TEA    = 2'd2
  } vend_state_t;

  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_COFFEE = 2'd1,
    PICK_TEA    = 2'd2
  } vend_pick_t;

endpackage

// File: rtl/vend_accept.sv
// Arbitrates the two request strobes and applies the strict price guard.
module vend_accept
  import vend_pkg::*;
#(
  parameter int AMT_W        = 8,
  parameter int COFFEE_PRICE = 50,
  parameter int TEA_PRICE    = 30
) (
  input  logic             coffee_req,
  input  logic [AMT_W-1:0] coffee_amt,
  input  logic             tea_req,
  input  logic [AMT_W-1:0] tea_amt,
  output vend_pick_t       pick,
  output logic [AMT_W-1:0] pick_amt
);
  localparam logic [AMT_W-1:0] PRICE_C = AMT_W'(COFFEE_PRICE);
  localparam logic [AMT_W-1:0] PRICE_T = AMT_W'(TEA_PRICE);

  always_comb begin
    pick     = PICK_NONE;
    pick_amt = '0;
    if (coffee_req) begin
      // a coffee strobe masks any tea strobe in the same cycle
      if (coffee_amt > PRICE_C) begin
        pick     = PICK_COFFEE;
        pick_amt = coffee_amt;
      end
    end else if (tea_req && (tea_amt > PRICE_T)) begin
      pick     = PICK_TEA;
      pick_amt = tea_amt;
    end
  end
endmodule

// File: rtl/vend_change.sv
// Subtracts the price of the drink being brewed from the held amount.
module vend_change
  import vend_pkg::*;
#(
  parameter int AMT_W        = 8,
  parameter int COFFEE_PRICE = 50,
  parameter int TEA_PRICE    = 30
) (
  input  vend_state_t      state,
  input  logic [AMT_W-1:0] held_amt,
  output logic [AMT_W-1:0] diff
);
  localparam logic [AMT_W-1:0] PRICE_C = AMT_W'(COFFEE_PRICE);
  localparam logic [AMT_W-1:0] PRICE_T = AMT_W'(TEA_PRICE);

  logic [AMT_W-1:0] price;

  always_comb begin
    case (state)
      ST_COFFEE: price = PRICE_C;
      ST_TEA:    price = PRICE_T;
      default:   price = '0;
    endcase
    diff = held_amt - price;
  end
endmodule

// File: rtl/vend_core.sv
// State register, held amount and registered output pulses.
module vend_core
  import vend_pkg::*;
#(
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  vend_pick_t       pick,
  input  logic [AMT_W-1:0] pick_amt,
  input  logic             brew_ready,
  input  logic [AMT_W-1:0] diff,
  output vend_state_t      state,
  output logic [AMT_W-1:0] held_amt,
  output logic             make_coffee,
  output logic             make_tea,
  output logic             pour_coffee,
  output logic             pour_tea,
  output logic             change_vld,
  output logic [AMT_W-1:0] change_amt
);
  vend_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      held_amt    <= '0;
      make_coffee <= 1'b0;
      make_tea    <= 1'b0;
      pour_coffee <= 1'b0;
      pour_tea    <= 1'b0;
      change_vld  <= 1'b0;
      change_amt  <= '0;
    end else begin
      make_coffee <= 1'b0;
      make_tea    <= 1'b0;
      pour_coffee <= 1'b0;
      pour_tea    <= 1'b0;
      change_vld  <= 1'b0;
      change_amt  <= '0;
      case (state_q)
        ST_IDLE: begin
          if (pick == PICK_COFFEE) begin
            state_q     <= ST_COFFEE;
            held_amt    <= pick_amt;
            make_coffee <= 1'b1;
          end else if (pick == PICK_TEA) begin
            state_q  <= ST_TEA;
            held_amt <= pick_amt;
            make_tea <= 1'b1;
          end
        end
        ST_COFFEE: begin
          if (brew_ready) begin
            state_q     <= ST_IDLE;
            pour_coffee <= 1'b1;
            change_vld  <= 1'b1;
            change_amt  <= diff;
          end
        end
        ST_TEA: begin
          if (brew_ready) begin
            state_q    <= ST_IDLE;
            pour_tea   <= 1'b1;
            change_vld <= 1'b1;
            change_amt <= diff;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state = state_q;
endmodule

// File: rtl/vend_event_ctrl.sv
module vend_event_ctrl
  import vend_pkg::*;
#(
  parameter int AMT_W        = 8,
  parameter int COFFEE_PRICE = 50,
  parameter int TEA_PRICE    = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coffee_req,
  input  logic [AMT_W-1:0] coffee_amt,
  input  logic             tea_req,
  input  logic [AMT_W-1:0] tea_amt,
  input  logic             brew_ready,
  output logic             make_coffee,
  output logic             make_tea,
  output logic             pour_coffee,
  output logic             pour_tea,
  output logic             change_vld,
  output logic [AMT_W-1:0] change_amt
);
  vend_pick_t       pick;
  logic [AMT_W-1:0] pick_amt;
  vend_state_t      state;
  logic [AMT_W-1:0] held_amt;
  logic [AMT_W-1:0] diff;

  vend_accept #(
    .AMT_W(AMT_W), .COFFEE_PRICE(COFFEE_PRICE), .TEA_PRICE(TEA_PRICE)
  ) u_accept (
    .coffee_req(coffee_req), .coffee_amt(coffee_amt),
    .tea_req(tea_req), .tea_amt(tea_amt),
    .pick(pick), .pick_amt(pick_amt)
  );

  vend_change #(
    .AMT_W(AMT_W), .COFFEE_PRICE(COFFEE_PRICE), .TEA_PRICE(TEA_PRICE)
  ) u_change (
    .state(state), .held_amt(held_amt), .diff(diff)
  );

  vend_core #(.AMT_W(AMT_W)) u_core (
    .clk(clk), .rst(rst),
    .pick(pick), .pick_amt(pick_amt),
    .brew_ready(brew_ready), .diff(diff),
    .state(state), .held_amt(held_amt),
    .make_coffee(make_coffee), .make_tea(make_tea),
    .pour_coffee(pour_coffee), .pour_tea(pour_tea),
    .change_vld(change_vld), .change_amt(change_amt)
  );
endmodule

// File: rtl/vend_event_ctrl_chk.sv
module vend_event_ctrl_chk #(
  parameter int AMT_W        = 8,
  parameter int COFFEE_PRICE = 50,
  parameter int TEA_PRICE    = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             coffee_req,
  input logic [AMT_W-1:0] coffee_amt,
  input logic             tea_req,
  input logic [AMT_W-1:0] tea_amt,
  input logic             brew_ready,
  input logic             make_coffee,
  input logic             make_tea,
  input logic             pour_coffee,
  input logic             pour_tea,
  input logic             change_vld,
  input logic [AMT_W-1:0] change_amt
);
  localparam logic [AMT_W-1:0] PRICE_C = AMT_W'(COFFEE_PRICE);
  localparam logic [AMT_W-1:0] PRICE_T = AMT_W'(TEA_PRICE);

  logic             busy;
  logic [AMT_W-1:0] prev_c_amt, prev_t_amt, kept_amt;

  // observer built from the ports: busy between a make pulse and its pour
  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      prev_c_amt <= '0;
      prev_t_amt <= '0;
      kept_amt   <= '0;
    end else begin
      prev_c_amt <= coffee_amt;
      prev_t_amt <= tea_amt;
      if (make_coffee) begin
        busy     <= 1'b1;
        kept_amt <= prev_c_amt;
      end else if (make_tea) begin
        busy     <= 1'b1;
        kept_amt <= prev_t_amt;
      end else if (pour_coffee || pour_tea) begin
        busy <= 1'b0;
      end
    end
  end

  a_r1_coffee_guard: assert property (@(posedge clk) disable iff (rst)
    make_coffee |-> ($past(coffee_req) && ($past(coffee_amt) > PRICE_C)));

  a_r2_tea_guard: assert property (@(posedge clk) disable iff (rst)
    make_tea |-> ($past(tea_req) && ($past(tea_amt) > PRICE_T)));

  a_r7_coffee_masks_tea: assert property (@(posedge clk) disable iff (rst)
    make_tea |-> !$past(coffee_req));

  a_r4_coffee_change: assert property (@(posedge clk) disable iff (rst)
    pour_coffee |-> (change_vld && (change_amt == kept_amt - PRICE_C)));

  a_r5_tea_change: assert property (@(posedge clk) disable iff (rst)
    pour_tea |-> (change_vld && (change_amt == kept_amt - PRICE_T)));

  a_r6_no_make_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(make_coffee || make_tea));

  a_r8_pour_needs_ready: assert property (@(posedge clk) disable iff (rst)
    (pour_coffee || pour_tea) |-> (busy && $past(brew_ready)));

  a_r9_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({make_coffee, make_tea, pour_coffee, pour_tea}));

  a_r9_make_pulse: assert property (@(posedge clk) disable iff (rst)
    (make_coffee || make_tea) |=> !(make_coffee || make_tea));

  a_r9_change_zero: assert property (@(posedge clk) disable iff (rst)
    !change_vld |-> (change_amt == '0));
endmodule

bind vend_event_ctrl vend_event_ctrl_chk #(
  .AMT_W(AMT_W), .COFFEE_PRICE(COFFEE_PRICE), .TEA_PRICE(TEA_PRICE)
) u_chk (.*);

// File: tb/vend_event_ctrl_tb.sv
module vend_event_ctrl_tb;
  localparam int W  = 8;
  localparam int PC = 50;
  localparam int PT = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coffee_req = 1'b0, tea_req = 1'b0, brew_ready = 1'b0;
  logic [W-1:0] coffee_amt = '0, tea_amt = '0;
  logic make_coffee, make_tea, pour_coffee, pour_tea, change_vld;
  logic [W-1:0] change_amt;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vend_event_ctrl #(.AMT_W(W), .COFFEE_PRICE(PC), .TEA_PRICE(PT)) u_dut (
    .clk(clk), .rst(rst),
    .coffee_req(coffee_req), .coffee_amt(coffee_amt),
    .tea_req(tea_req), .tea_amt(tea_amt),
    .brew_ready(brew_ready),
    .make_coffee(make_coffee), .make_tea(make_tea),
    .pour_coffee(pour_coffee), .pour_tea(pour_tea),
    .change_vld(change_vld), .change_amt(change_amt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs at a falling edge; outputs of the edge are
  // observed at the following falling edge
  task automatic step(input logic cr, input int ca, input logic tr,
                      input int ta, input logic rdy);
    coffee_req = cr; coffee_amt = W'(ca);
    tea_req = tr; tea_amt = W'(ta);
    brew_ready = rdy;
    @(negedge clk);
    coffee_req = 0; tea_req = 0; brew_ready = 0;
    coffee_amt = '0; tea_amt = '0;
  endtask

  task automatic chk_outs(input string req, input int mc, input int mt,
                          input int pc, input int pt, input int cv, input int ca);
    chk(req, "make_coffee", int'(make_coffee), mc);
    chk(req, "make_tea", int'(make_tea), mt);
    chk(req, "pour_coffee", int'(pour_coffee), pc);
    chk(req, "pour_tea", int'(pour_tea), pt);
    chk(req, "change_vld", int'(change_vld), cv);
    chk(req, "change_amt", int'(change_amt), ca);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_outs("R10", 0, 0, 0, 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic t_coffee(input int amt);
    step(1, amt, 0, 0, 0);
    chk_outs("R1", 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk_outs("R9", 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk_outs("R4", 0, 0, 1, 0, 1, amt - PC);
    step(0, 0, 0, 0, 0);
    chk_outs("R9", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_tea(input int amt);
    step(0, 0, 1, amt, 0);
    chk_outs("R2", 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk_outs("R5", 0, 0, 0, 1, 1, amt - PT);
    step(0, 0, 0, 0, 0);
    chk_outs("R9", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reject;
    step(1, PC, 0, 0, 0);
    chk_outs("R3", 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, PT, 0);
    chk_outs("R3", 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk_outs("R3", 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk_outs("R3", 0, 0, 0, 0, 0, 0);
    t_tea(PT + 1);
  endtask

  task automatic t_ready_idle;
    step(0, 0, 0, 0, 1);
    chk_outs("R8", 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk_outs("R8", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_busy_ignore;
    step(1, 60, 0, 0, 0);
    chk_outs("R1", 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 200, 0);
    chk_outs("R6", 0, 0, 0, 0, 0, 0);
    step(1, 255, 0, 0, 0);
    chk_outs("R6", 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 40, 1);
    chk_outs("R6", 0, 0, 1, 0, 1, 10);
    step(0, 0, 1, 40, 0);
    chk_outs("R6", 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk_outs("R5", 0, 0, 0, 1, 1, 10);
  endtask

  task automatic t_both;
    step(1, PC + 1, 1, 100, 0);
    chk_outs("R7", 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk_outs("R7", 0, 0, 1, 0, 1, 1);
    step(1, 10, 1, 100, 0);
    chk_outs("R7", 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk_outs("R7", 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_coffee(PC + 1);
    t_coffee(255);
    t_tea(255);
    t_tea(100);
    t_reject();
    t_ready_idle();
    t_busy_ignore();
    t_both();
    step(1, 80, 0, 0, 0);
    t_reset();
    step(0, 0, 0, 0, 1);
    chk_outs("R10", 0, 0, 0, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule